// File: doc/BRIEF.md
# Signed Sample to BCD Converter

This block accepts a 16-bit sensor sample, of which only the low ten bits carry information. Those ten bits are read as a two's-complement number. The block multiplies the absolute value by four and expands the result into four decimal digits, ones through thousands, in binary-coded decimal. It also raises a sign flag for negative readings and passes the ten-bit field through unchanged on a separate output.

The conversion uses the shift-and-add-3 method on an 11-bit magnitude and needs no divider. The logic is combinational and is followed by one bank of output registers. The most negative code cannot be shown as a magnitude, so it displays as zero and the sign flag stays low. The block sits between a sensor interface and a decimal display driver.

Top module: `sample_bcd_conv`

## Requirements
- R1: `field_out` equals bits [9:0] of the `sample_in` value present at the previous rising clock edge.
- R2: Bits [15:10] of `sample_in` have no effect on any output.
- R3: For a field value D from 0 to 511, the digits read as the decimal number 4*D.
- R4: For a field value D from 513 to 1023 (unsigned reading of the ten bits), the digits read as 4*(1024-D), which is four times the absolute value.
- R5: The field value 512 gives all four digits equal to 0 and `neg_out` equal to 0.
- R6: `neg_out` is 1 exactly when bit 9 of the field is 1 and the field is not 512.
- R7: No digit output is ever greater than 9. The largest reading, 2044, fits in the four digits.
- R8: All outputs are registered. A synchronous active-high `rst` clears every output to 0 on the next rising edge, and results appear one clock after the sample is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 16 | Raw sensor sample. Only bits [9:0] are used |
| field_out | output | 10 | Registered copy of the ten-bit field |
| neg_out | output | 1 | Sign of the displayed value |
| dig_ones | output | 4 | BCD ones digit |
| dig_tens | output | 4 | BCD tens digit |
| dig_hund | output | 4 | BCD hundreds digit |
| dig_thou | output | 4 | BCD thousands digit |

## Verification
Two corrections can act in the same cycle: the sign-flag suppression and the forced-zero magnitude. Both fire on the code 512 and must agree, so the output shows zero with no minus sign. The bench provokes this by applying 512 with several different upper-bit patterns, and it also places 512 directly after -1 (1023) and after 511, so that a flag or digit left over from the previous sample would show. A behavioural model computes the expected values with integer arithmetic and compares every output on every clock. The flag, the digits and the pass-through field are each judged separately against that model.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Width of the raw sample word
    parameter int SAMPLE_W = 16;
    // Width of the meaningful two's-complement field
    parameter int FIELD_W  = 10;
    // Left shift applied to the magnitude (x4)
    parameter int SCALE_SH = 2;
    // Number of BCD digits produced
    parameter int DIGITS   = 4;

    // Absolute value needs FIELD_W-1 bits once the minimum code is forced to zero
    localparam int ABS_W = FIELD_W - 1;
    // Scaled magnitude width
    localparam int MAG_W = ABS_W + SCALE_SH;
    // Total width of the shift-and-add-3 working register
    localparam int DD_W  = MAG_W + 4 * DIGITS;

    typedef logic [DIGITS-1:0][3:0] bcd_vec_t;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic               neg;
        bcd_vec_t           digits;
    } conv_result_t;

    // Correction step: a digit of five or more gets three added before the shift
    function automatic logic [3:0] add3_fix(input logic [3:0] nib);
        logic [3:0] r;
        if (nib >= 4'd5) r = nib + 4'd3;
        else             r = nib;
        return r;
    endfunction

    // Most negative field code: only the sign bit set
    function automatic logic is_min_code(input logic [FIELD_W-1:0] f);
        return f == {1'b1, {(FIELD_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/sbc_signmag.sv
module sbc_signmag
    import sbc_pkg::*;
(
    input  logic [FIELD_W-1:0] field_i,
    output logic               neg_o,
    output logic [MAG_W-1:0]   mag_o
);

    logic               min_code;
    logic [FIELD_W-1:0] negated;
    logic [FIELD_W-1:0] abs_full;
    logic [ABS_W-1:0]   abs_trim;
    logic               unused_abs_msb;

    assign min_code = is_min_code(field_i);
    assign negated  = (~field_i) + {{(FIELD_W-1){1'b0}}, 1'b1};

    always_comb begin
        if (field_i[FIELD_W-1]) abs_full = negated;
        else                    abs_full = field_i;
    end

    // For the minimum code the top bit of abs_full is set; drop it to reach zero
    assign unused_abs_msb = abs_full[FIELD_W-1];

    always_comb begin
        if (min_code) abs_trim = '0;
        else          abs_trim = abs_full[ABS_W-1:0];
    end

    generate
        if (SCALE_SH > 0) begin : g_scale
            assign mag_o = {abs_trim, {SCALE_SH{1'b0}}};
        end else begin : g_noscale
            assign mag_o = abs_trim;
        end
    endgenerate

    assign neg_o = field_i[FIELD_W-1] & ~min_code;

endmodule

// File: rtl/sbc_dd_stage.sv
module sbc_dd_stage
    import sbc_pkg::*;
(
    input  logic [DD_W-1:0] din,
    output logic [DD_W-1:0] dout
);

    logic [DD_W-1:0] adj;
    logic            unused_top;

    assign adj[MAG_W-1:0] = din[MAG_W-1:0];

    generate
        for (genvar k = 0; k < DIGITS; k++) begin : g_dig
            assign adj[MAG_W + 4*k +: 4] = add3_fix(din[MAG_W + 4*k +: 4]);
        end
    endgenerate

    // The top bit is always zero for magnitudes that fit the digit count
    assign unused_top = adj[DD_W-1];
    assign dout       = {adj[DD_W-2:0], 1'b0};

endmodule

// File: rtl/sbc_dabble.sv
module sbc_dabble
    import sbc_pkg::*;
(
    input  logic [MAG_W-1:0] mag_i,
    output bcd_vec_t         bcd_o
);

    logic [DD_W-1:0] chain [0:MAG_W];
    logic [MAG_W-1:0] unused_tail;

    assign chain[0] = {{(4*DIGITS){1'b0}}, mag_i};

    generate
        for (genvar s = 0; s < MAG_W; s++) begin : g_stage
            sbc_dd_stage u_stage (
                .din  (chain[s]),
                .dout (chain[s+1])
            );
        end
    endgenerate

    assign unused_tail = chain[MAG_W][MAG_W-1:0];
    assign bcd_o       = chain[MAG_W][MAG_W +: 4*DIGITS];

endmodule

// File: rtl/sample_bcd_conv.sv
module sample_bcd_conv
    import sbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [FIELD_W-1:0]  field_out,
    output logic                neg_out,
    output logic [3:0]          dig_ones,
    output logic [3:0]          dig_tens,
    output logic [3:0]          dig_hund,
    output logic [3:0]          dig_thou
);

    logic [FIELD_W-1:0]          field_w;
    logic [SAMPLE_W-FIELD_W-1:0] unused_hi;
    logic                        neg_w;
    logic [MAG_W-1:0]            mag_w;
    bcd_vec_t                    bcd_w;
    conv_result_t                nxt;
    conv_result_t                res_q;

    assign field_w   = sample_in[FIELD_W-1:0];
    assign unused_hi = sample_in[SAMPLE_W-1:FIELD_W];

    sbc_signmag u_signmag (
        .field_i (field_w),
        .neg_o   (neg_w),
        .mag_o   (mag_w)
    );

    sbc_dabble u_dabble (
        .mag_i (mag_w),
        .bcd_o (bcd_w)
    );

    always_comb begin
        nxt.field  = field_w;
        nxt.neg    = neg_w;
        nxt.digits = bcd_w;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= nxt;
    end

    assign field_out = res_q.field;
    assign neg_out   = res_q.neg;
    assign dig_ones  = res_q.digits[0];
    assign dig_tens  = res_q.digits[1];
    assign dig_hund  = res_q.digits[2];
    assign dig_thou  = res_q.digits[3];

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
    import sbc_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [SAMPLE_W-1:0] sample_in,
    input logic [FIELD_W-1:0]  field_out,
    input logic                neg_out,
    input logic [3:0]          dig_ones,
    input logic [3:0]          dig_tens,
    input logic [3:0]          dig_hund,
    input logic [3:0]          dig_thou
);

    // R7: every digit stays within 0..9
    a_r7_digit_range: assert property (@(posedge clk) disable iff (rst)
        (dig_ones <= 4'd9) && (dig_tens <= 4'd9) && (dig_hund <= 4'd9) && (dig_thou <= 4'd9));

    // R1: registered field follows the low bits of the input one clock later
    a_r1_field_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> field_out == $past(sample_in[FIELD_W-1:0]));

    // R6: sign flag tracks the sign bit, with the minimum code excluded
    a_r6_neg_flag: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> neg_out == ($past(sample_in[FIELD_W-1]) &&
                             !is_min_code($past(sample_in[FIELD_W-1:0]))));

    // R5: a negative sign never comes with a zero display
    a_r5_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
        neg_out |-> ({dig_thou, dig_hund, dig_tens, dig_ones} != 16'h0000));

    // R3: scaled value is a multiple of four, so the ones digit is even
    a_r3_ones_even: assert property (@(posedge clk) disable iff (rst)
        dig_ones[0] == 1'b0);

    // R8: reset clears all outputs on the following edge
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (field_out == '0) && !neg_out &&
                ({dig_thou, dig_hund, dig_tens, dig_ones} == 16'h0000));

endmodule

bind sample_bcd_conv sbc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_in (sample_in),
    .field_out (field_out),
    .neg_out   (neg_out),
    .dig_ones  (dig_ones),
    .dig_tens  (dig_tens),
    .dig_hund  (dig_hund),
    .dig_thou  (dig_thou)
);

// File: tb/sample_bcd_conv_tb.sv
module sample_bcd_conv_tb;

    logic        clk;
    logic        rst;
    logic [15:0] sample_in;
    logic [9:0]  field_out;
    logic        neg_out;
    logic [3:0]  dig_ones;
    logic [3:0]  dig_tens;
    logic [3:0]  dig_hund;
    logic [3:0]  dig_thou;

    int n_vec;
    int n_bad;
    bit done;

    int exp_q[$];

    sample_bcd_conv u_dut (
        .clk       (clk),
        .rst       (rst),
        .sample_in (sample_in),
        .field_out (field_out),
        .neg_out   (neg_out),
        .dig_ones  (dig_ones),
        .dig_tens  (dig_tens),
        .dig_hund  (dig_hund),
        .dig_thou  (dig_thou)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic int model_mag(input int f);
        if (f < 512)       return 4 * f;
        else if (f == 512) return 0;
        else               return 4 * (1024 - f);
    endfunction

    task automatic compare(input int f, input string tag);
        int m;
        int e_neg;
        int act_val;
        bit bad;
        m       = model_mag(f);
        e_neg   = (f > 512) ? 1 : 0;
        act_val = dig_thou * 1000 + dig_hund * 100 + dig_tens * 10 + dig_ones;
        bad     = 1'b0;
        n_vec++;
        if (int'(field_out) != f) begin
            $display("FAIL R1 %s: field_out=%0d expected %0d", tag, field_out, f);
            bad = 1'b1;
        end
        if (int'(neg_out) != e_neg) begin
            $display("FAIL R6 %s field=%0d: neg_out=%0d expected %0d", tag, f, neg_out, e_neg);
            bad = 1'b1;
        end
        if (dig_ones > 9 || dig_tens > 9 || dig_hund > 9 || dig_thou > 9) begin
            $display("FAIL R7 %s field=%0d: digits %0d%0d%0d%0d expected all <=9",
                     tag, f, dig_thou, dig_hund, dig_tens, dig_ones);
            bad = 1'b1;
        end
        if (act_val != m) begin
            $display("FAIL %s %s field=%0d: value=%0d expected %0d",
                     (f < 512) ? "R3" : ((f == 512) ? "R5" : "R4"), tag, f, act_val, m);
            bad = 1'b1;
        end
        if (bad) n_bad++;
    endtask

    // Apply one sample at a falling edge and judge the result one clock later
    task automatic apply(input logic [15:0] s, input string tag);
        int f;
        @(negedge clk);
        sample_in = s;
        exp_q.push_back(int'(s[9:0]));
        @(negedge clk);
        f = exp_q.pop_front();
        compare(f, tag);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            $display("FAIL watchdog: run did not finish, expected completion");
            n_bad++;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        n_vec = 0;
        n_bad = 0;
        done  = 1'b0;
        rst   = 1'b1;
        sample_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R8: outputs cleared while reset is held
        n_vec++;
        if (field_out !== 10'd0 || neg_out !== 1'b0 ||
            {dig_thou, dig_hund, dig_tens, dig_ones} !== 16'h0000) begin
            $display("FAIL R8 reset: field=%0d neg=%0d digits=%h expected all zero",
                     field_out, neg_out, {dig_thou, dig_hund, dig_tens, dig_ones});
            n_bad++;
        end
        rst = 1'b0;

        // R3, R4: full sweep of field codes, upper bits varied (R2)
        for (int i = 0; i < 1024; i++) begin
            logic [5:0] hi;
            hi = 6'(i * 37 + 5);
            apply({hi, 10'(i)}, "sweep R2");
        end

        // R5 with R6 in the same cycle: minimum code after various neighbours
        apply(16'h03FF, "before-min");
        apply(16'h0200, "min R5");
        apply(16'h01FF, "max-pos R3");
        apply(16'hFE00, "min hi-set R2 R5");
        apply(16'h0000, "zero R3");
        apply(16'hAA00 | 16'h0200, "min hi-pattern R5");
        apply(16'h0201, "min+1 R4");

        // R2: same field under different upper bits
        apply(16'h0123, "lowhi R2");
        apply(16'hFD23, "highhi R2");
        apply(16'h7F7F, "mix R2");

        // R8: reset clears outputs after a nonzero result
        @(negedge clk);
        sample_in = 16'h01FF;
        rst = 1'b1;
        @(negedge clk);
        n_vec++;
        if (field_out !== 10'd0 || neg_out !== 1'b0 ||
            {dig_thou, dig_hund, dig_tens, dig_ones} !== 16'h0000) begin
            $display("FAIL R8 mid-run reset: field=%0d neg=%0d digits=%h expected all zero",
                     field_out, neg_out, {dig_thou, dig_hund, dig_tens, dig_ones});
            n_bad++;
        end
        rst = 1'b0;
        apply(16'h0300, "after-reset R4");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule